// File: doc/BRIEF.md
# PHY Test-Interface Writer

This block writes a single configuration byte into a PHY's internal register space. It drives the PHY's three-wire test port: a test clock, a test enable and an 8-bit data bus. A requester hands over an 8-bit register code and an 8-bit data byte through a valid/ready handshake. The engine then steps the pins through a fixed seven-step pattern. The PHY takes the code on the falling test-clock edge while enable is high, and it takes the data on the following rising edge while enable is low. When the pattern is complete, the engine pulses `done`.

Every step stays on the pins for a programmable number of system clocks, so the PHY's setup and hold margins can be tuned without changing the RTL. The same request port can also ask for a clear operation. In that case the engine raises the test-clear line with the test clock held high, drops the line again, and waits for a second fixed interval before it reports `done`. Both intervals are set by a parameter.

Top module: `phy_tif_writer`

## Requirements
- R1: After reset the test clock is 1, test enable is 0, test clear is 0, the data bus is 0, `done` is 0 and `req_ready` is 1.
- R2: A write (`req_clear`=0) drives these pin patterns in this order, as {clock, enable, bus}: {1,0,0}, {1,0,code}, {1,1,code}, {0,1,code}, {0,0,code}, {0,0,data}, {1,0,data}. It then returns to idle.
- R3: Each write step lasts exactly `hold_cycles`+1 system clocks.
- R4: `hold_cycles`, code and data are sampled when the request is accepted. Changing `hold_cycles` during a transaction has no effect on that transaction.
- R5: On every falling test-clock edge, enable is high and the bus is unchanged from the cycle before. On every rising test-clock edge, enable is low.
- R6: `req_ready` is low from the cycle after acceptance until `done` rises. `done` is high for exactly one cycle per transaction, and `req_ready` is high in that cycle.
- R7: Whenever `req_ready` is 1, test enable is 0, the bus is 0, test clear is 0 and the test clock is 1.
- R8: A clear request (`req_clear`=1) holds test clear at 1 with the test clock at 1 for `CLR_CYCLES` clocks. It then holds test clear at 0 for `CLR_CYCLES` clocks, and then pulses `done`. Enable and the bus stay 0 throughout, and code and data are ignored.
- R9: A request presented while the engine is busy is not taken. No extra transaction follows the current one once the request is withdrawn before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_cycles | input | HOLD_W | Step length minus one, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_clear | input | 1 | 1 selects a clear operation, 0 a write |
| req_code | input | 8 | Register code for a write |
| req_data | input | 8 | Data byte for a write |
| done | output | 1 | One-cycle completion pulse |
| tif_clk | output | 1 | Test clock to the PHY |
| tif_en | output | 1 | Test enable to the PHY |
| tif_clr | output | 1 | Test clear to the PHY |
| tif_din | output | 8 | Test data bus to the PHY |

## Verification
Writes are tried with step lengths of one, two, three, six and 256 clocks. They use codes and data chosen so that neighbouring steps can be told apart, including all-zero and all-one bytes and a case where code and data are equal. Each pattern is compared sample by sample, which exposes a swapped step, a wrong edge or a step length that is off by one. A change of `hold_cycles` in mid-flight separates sampling at acceptance from sampling the live input. A request asserted during a busy write shows whether a second transaction leaks through. A clear with non-zero code and data shows that the bus stays quiet and that both intervals are exact.

// File: rtl/phy_tif_pkg.sv
package phy_tif_pkg;

    localparam int TIF_DW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_HI,
        ST_CODE,
        ST_EN_HI,
        ST_CLK_LO,
        ST_EN_LO,
        ST_DATA,
        ST_CLK_RISE,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_DONE
    } tif_state_e;

    typedef struct packed {
        logic              clr;
        logic              clk;
        logic              en;
        logic [TIF_DW-1:0] din;
    } tif_pins_t;

    localparam tif_pins_t PINS_IDLE = '{clr: 1'b0, clk: 1'b1, en: 1'b0, din: '0};

    // Next step of the write pattern; the last one hands over to ST_DONE.
    function automatic tif_state_e next_write_step(tif_state_e s);
        case (s)
            ST_CLK_HI: return ST_CODE;
            ST_CODE:   return ST_EN_HI;
            ST_EN_HI:  return ST_CLK_LO;
            ST_CLK_LO: return ST_EN_LO;
            ST_EN_LO:  return ST_DATA;
            ST_DATA:   return ST_CLK_RISE;
            default:   return ST_DONE;
        endcase
    endfunction

    function automatic logic is_write_step(tif_state_e s);
        return (s == ST_CLK_HI) || (s == ST_CODE) || (s == ST_EN_HI) ||
               (s == ST_CLK_LO) || (s == ST_EN_LO) || (s == ST_DATA) ||
               (s == ST_CLK_RISE);
    endfunction

    // Pin levels that belong to each state.
    function automatic tif_pins_t pins_for(tif_state_e s,
                                           logic [TIF_DW-1:0] code,
                                           logic [TIF_DW-1:0] data);
        tif_pins_t p;
        p = PINS_IDLE;
        case (s)
            ST_CODE:     p.din = code;
            ST_EN_HI:    begin p.din = code; p.en = 1'b1; end
            ST_CLK_LO:   begin p.din = code; p.en = 1'b1; p.clk = 1'b0; end
            ST_EN_LO:    begin p.din = code; p.clk = 1'b0; end
            ST_DATA:     begin p.din = data; p.clk = 1'b0; end
            ST_CLK_RISE: p.din = data;
            ST_CLR_HI:   p.clr = 1'b1;
            default:     p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tif_step_timer.sv
module tif_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3: an expired count stays expired until reloaded
    timer_hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/tif_sequencer.sv
module tif_sequencer
    import phy_tif_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int CLR_CYCLES = 16,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_clear,
    input  logic [TIF_DW-1:0] req_code,
    input  logic [TIF_DW-1:0] req_data,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              req_ready,
    input  logic              timer_zero,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output tif_pins_t         pins_nxt,
    output logic              done_nxt
);
    localparam logic [CNT_W-1:0] CLR_LOAD = CNT_W'(CLR_CYCLES - 1);

    tif_state_e        state_q, state_n;
    logic [TIF_DW-1:0] code_q, data_q;
    logic [HOLD_W-1:0] hold_q;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_n    = state_q;
        timer_load = 1'b0;
        timer_val  = CNT_W'(hold_q);
        if (state_q == ST_IDLE) begin
            if (req_valid) begin
                timer_load = 1'b1;
                if (req_clear) begin
                    state_n   = ST_CLR_HI;
                    timer_val = CLR_LOAD;
                end else begin
                    state_n   = ST_CLK_HI;
                    timer_val = CNT_W'(hold_cycles);
                end
            end
        end else if (is_write_step(state_q)) begin
            if (timer_zero) begin
                state_n    = next_write_step(state_q);
                timer_load = 1'b1;
            end
        end else if (state_q == ST_CLR_HI) begin
            if (timer_zero) begin
                state_n    = ST_CLR_LO;
                timer_load = 1'b1;
                timer_val  = CLR_LOAD;
            end
        end else if (state_q == ST_CLR_LO) begin
            if (timer_zero)
                state_n = ST_DONE;
        end else begin
            state_n = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            data_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                code_q <= req_code;
                data_q <= req_data;
                hold_q <= hold_cycles;
            end
        end
    end

    assign pins_nxt = pins_for(state_q, code_q, data_q);
    assign done_nxt = (state_q == ST_DONE);

    // R6
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(hold_q));

endmodule

// File: rtl/tif_pin_reg.sv
module tif_pin_reg
    import phy_tif_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tif_pins_t pins_nxt,
    input  logic      done_nxt,
    output tif_pins_t pins,
    output logic      done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PINS_IDLE;
            done <= 1'b0;
        end else begin
            pins <= pins_nxt;
            done <= done_nxt;
        end
    end

    // R5
    fall_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.clk) |-> pins.en);

    // R5
    rise_without_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.clk) |-> !pins.en);

    // R5
    bus_steady_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.clk) |-> $stable(pins.din));

    // R8
    clr_with_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        pins.clr |-> (pins.clk && !pins.en));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/phy_tif_writer.sv
module phy_tif_writer
    import phy_tif_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int CLR_CYCLES = 15000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clear,
    input  logic [TIF_DW-1:0] req_code,
    input  logic [TIF_DW-1:0] req_data,
    output logic              done,
    output logic              tif_clk,
    output logic              tif_en,
    output logic              tif_clr,
    output logic [TIF_DW-1:0] tif_din
);
    localparam int CLR_W = $clog2(CLR_CYCLES + 1);
    localparam int CNT_W = (CLR_W > HOLD_W) ? CLR_W : HOLD_W;

    logic             timer_load, timer_zero, done_nxt;
    logic [CNT_W-1:0] timer_val;
    tif_pins_t        pins_nxt, pins;

    tif_step_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .zero     (timer_zero)
    );

    tif_sequencer #(
        .HOLD_W     (HOLD_W),
        .CLR_CYCLES (CLR_CYCLES),
        .CNT_W      (CNT_W)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_clear   (req_clear),
        .req_code    (req_code),
        .req_data    (req_data),
        .hold_cycles (hold_cycles),
        .req_ready   (req_ready),
        .timer_zero  (timer_zero),
        .timer_load  (timer_load),
        .timer_val   (timer_val),
        .pins_nxt    (pins_nxt),
        .done_nxt    (done_nxt)
    );

    tif_pin_reg i_pins (
        .clk      (clk),
        .rst      (rst),
        .pins_nxt (pins_nxt),
        .done_nxt (done_nxt),
        .pins     (pins),
        .done     (done)
    );

    assign tif_clk = pins.clk;
    assign tif_en  = pins.en;
    assign tif_clr = pins.clr;
    assign tif_din = pins.din;

    // R7
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (tif_clk && !tif_en && !tif_clr && tif_din == '0));

    // R6
    done_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

endmodule

// File: tb/test_phy_tif_writer.sv
module test_phy_tif_writer;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_W     = 8;
    localparam int CLR_CYC    = 20;
    localparam int MAXS       = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [HOLD_W-1:0] hold_cycles = '0;
    logic              req_valid = 1'b0;
    logic              req_clear = 1'b0;
    logic [7:0]        req_code = '0;
    logic [7:0]        req_data = '0;
    logic              req_ready, done, tif_clk, tif_en, tif_clr;
    logic [7:0]        tif_din;

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 0;

    logic [10:0] cap [MAXS];
    logic [10:0] exq [MAXS];
    int cap_n, exp_n, rdy_bad;

    phy_tif_writer #(.HOLD_W(HOLD_W), .CLR_CYCLES(CLR_CYC)) i_phy_tif_writer (
        .clk(clk), .rst(rst), .hold_cycles(hold_cycles), .req_valid(req_valid),
        .req_ready(req_ready), .req_clear(req_clear), .req_code(req_code),
        .req_data(req_data), .done(done), .tif_clk(tif_clk), .tif_en(tif_en),
        .tif_clr(tif_clr), .tif_din(tif_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [10:0] pv(bit c, bit k, bit e, logic [7:0] d);
        return {c, k, e, d};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic add_exp(logic [10:0] v, int n);
        for (int i = 0; i < n; i++) begin
            exq[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic build_write(logic [7:0] c, logic [7:0] d, int hold);
        exp_n = 0;
        add_exp(pv(0, 1, 0, 8'h00), hold + 1);
        add_exp(pv(0, 1, 0, c),     hold + 1);
        add_exp(pv(0, 1, 1, c),     hold + 1);
        add_exp(pv(0, 0, 1, c),     hold + 1);
        add_exp(pv(0, 0, 0, c),     hold + 1);
        add_exp(pv(0, 0, 0, d),     hold + 1);
        add_exp(pv(0, 1, 0, d),     hold + 1);
    endtask

    // Presents a request at a falling edge; it is taken at the next rising edge.
    task automatic issue(bit clr, logic [7:0] c, logic [7:0] d, int hold);
        @(negedge clk);
        chk(req_ready, "R6", "ready before request", req_ready, 1);
        req_clear = clr; req_code = c; req_data = d;
        hold_cycles = HOLD_W'(hold); req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Samples the pins once per cycle until done is seen.
    task automatic capture();
        cap_n = 0; rdy_bad = 0;
        @(negedge clk);
        if (req_ready || done) rdy_bad++;
        while (1) begin
            @(negedge clk);
            if (done) break;
            cap[cap_n] = {tif_clr, tif_clk, tif_en, tif_din};
            cap_n++;
            if (req_ready) rdy_bad++;
            if (cap_n >= MAXS) break;
        end
    endtask

    task automatic compare(string req);
        int bad = -1;
        chk(cap_n == exp_n, req, "sequence length", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && cap[i] !== exq[i]) bad = i;
        if (bad >= 0)
            chk(0, req, $sformatf("pin pattern at sample %0d", bad), cap[bad], exq[bad]);
        else
            chk(1, req, "pin pattern", 0, 0);
    endtask

    // Checks taken at the done cycle and the one after it.
    task automatic finish_checks();
        chk(rdy_bad == 0, "R6", "ready low while busy", rdy_bad, 0);
        chk(req_ready, "R6", "ready with done", req_ready, 1);
        @(negedge clk);
        chk(!done, "R6", "done one cycle", done, 0);
        chk(tif_clk && !tif_en && !tif_clr && tif_din == 0, "R7", "idle pins",
            {tif_clr, tif_clk, tif_en, tif_din}, pv(0, 1, 0, 0));
    endtask

    task automatic t_reset();
        chk(tif_clk && !tif_en && !tif_clr && tif_din == 0, "R1", "reset pins",
            {tif_clr, tif_clk, tif_en, tif_din}, pv(0, 1, 0, 0));
        chk(!done && req_ready, "R1", "reset done/ready", {done, req_ready}, 2'b01);
    endtask

    task automatic t_write(logic [7:0] c, logic [7:0] d, int hold);
        build_write(c, d, hold);
        issue(0, c, d, hold);
        capture();
        compare($sformatf("R2 R3 R5 hold=%0d", hold));
        finish_checks();
    endtask

    task automatic t_hold_change();
        build_write(8'h3A, 8'h7E, 2);
        issue(0, 8'h3A, 8'h7E, 2);
        fork
            capture();
            begin
                repeat (4) @(negedge clk);
                hold_cycles = 8'd6;
            end
        join
        compare("R4");
        finish_checks();
    endtask

    task automatic t_busy_ignore();
        build_write(8'h81, 8'h18, 1);
        issue(0, 8'h81, 8'h18, 1);
        fork
            capture();
            begin
                repeat (3) @(negedge clk);
                req_code = 8'hEE; req_data = 8'hDD; req_valid = 1'b1;
                repeat (4) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        compare("R9");
        finish_checks();
        begin
            int extra = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (done || !req_ready || tif_din != 0) extra++;
            end
            chk(extra == 0, "R9", "no extra transaction", extra, 0);
        end
    endtask

    task automatic t_clear();
        exp_n = 0;
        add_exp(pv(1, 1, 0, 8'h00), CLR_CYC);
        add_exp(pv(0, 1, 0, 8'h00), CLR_CYC);
        issue(1, 8'hC5, 8'h5C, 3);
        capture();
        compare("R8");
        finish_checks();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!summary_done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary_done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(8'hA5, 8'h3C, 0);
        t_write(8'h5A, 8'hC3, 2);
        t_write(8'hFF, 8'h00, 1);
        t_write(8'h00, 8'hFF, 5);
        t_write(8'h44, 8'h44, 0);
        t_write(8'h69, 8'h96, 255);
        t_hold_change();
        t_busy_ignore();
        t_clear();
        t_write(8'h12, 8'h34, 3);
        if (!summary_done) begin
            summary_done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule